// File: doc/BRIEF.md
# Selectable Arithmetic and Logic Unit

This block is a purely combinational ALU of parameterised width (four bits by default). It takes two operands, a carry input, a two-bit operation select and a mode bit. It returns a result word and a carry output. There is no clock and no storage, so the outputs follow the inputs within the same cycle.

In arithmetic mode, one adder produces every arithmetic result. A per-bit generator turns the second operand into one of four values: zero, the operand itself, its bitwise complement, or all ones. That value is added to the first operand together with the carry input, through a ripple chain of full adders. Because the carry input is an independent operation bit, the same hardware covers the following operations:

- transfer
- increment
- add
- add with carry
- ones'-complement difference
- two's-complement subtraction
- decrement

In logic mode, a four-way selection picks one bitwise function of the operands. A final two-way selection, driven by the mode bit, routes one of the two halves to the result.

The carry output is the unsigned carry out of the top bit. A wider operand can therefore be processed by chaining instances, feeding one instance's carry output to the next instance's carry input.

Top module: `sel_alu`

## Requirements
- R1: With `logic_mode`=0 and `op_sel`=2'b00, `res` equals `opa` + `cin`. `cin`=0 transfers `opa` with `cout`=0. `cin`=1 increments `opa`, and `cout`=1 only when `opa` is all ones.
- R2: With `logic_mode`=0 and `op_sel`=2'b01, {`cout`,`res`} equals `opa` + `opb` + `cin`.
- R3: With `logic_mode`=0 and `op_sel`=2'b10, {`cout`,`res`} equals `opa` + ~`opb` + `cin`. With `cin`=1 this is `opa` − `opb` modulo 2^W, and `cout`=1 exactly when `opa` ≥ `opb` (unsigned).
- R4: With `logic_mode`=0 and `op_sel`=2'b11, the second adder operand is all ones. `cin`=0 gives `opa` − 1 with `cout`=1 exactly when `opa` is nonzero. `cin`=1 gives `opa` unchanged with `cout`=1.
- R5: With `logic_mode`=1, `res` is chosen by `op_sel` as follows: 2'b00 gives `opa` | `opb`, 2'b01 gives `opa` & `opb`, 2'b10 gives `opa` ^ `opb`, and 2'b11 gives ~`opa`.
- R6: With `logic_mode`=1, `cout` is 0 and `cin` has no effect on `res`.
- R7: `cout` is the carry out of bit W−1 of the arithmetic sum. Two passes chained through `cout` into `cin` produce the correct 2W-bit sum and difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand, fed straight to the adder and to the logic functions |
| opb | input | W | Second operand, shaped by the operand generator in arithmetic mode |
| cin | input | 1 | Carry input; acts as an operation bit in arithmetic mode |
| op_sel | input | 2 | Operation select for both halves |
| logic_mode | input | 1 | 0 selects the arithmetic result, 1 selects the logic result |
| res | output | W | Result word |
| cout | output | 1 | Carry out of the top bit; 0 in logic mode |

## Verification
Every combination of `op_sel`, `cin` and `logic_mode` is swept exhaustively over all 4-bit operand pairs. This separates a wrong operand-generator leg, a misrouted carry input and a swapped logic function from one another. Directed corner operands target the carry output specifically:

- a zero operand under decrement
- an all-ones operand under increment
- equal operands under subtraction

Each of these sits on the boundary where `cout` flips. Finally, 8-bit additions and subtractions are composed from two chained 4-bit passes, which confirms that the carry output is usable as a carry input.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

  typedef enum logic [1:0] {
    YG_ZERO = 2'b00,
    YG_PASS = 2'b01,
    YG_INV  = 2'b10,
    YG_ONES = 2'b11
  } yg_sel_e;

  typedef enum logic [1:0] {
    LF_OR   = 2'b00,
    LF_AND  = 2'b01,
    LF_XOR  = 2'b10,
    LF_NOTA = 2'b11
  } lf_sel_e;

endpackage

// File: rtl/sel_alu_opgen.sv
module sel_alu_opgen #(
  parameter int W = 4
) (
  input  logic [W-1:0] b_in,
  input  logic [1:0]   sel,
  output logic [W-1:0] y_out
);
  import sel_alu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // Two AND legs: the low select bit passes the operand bit, the high one passes its inverse.
    assign y_out[i] = (sel[0] & b_in[i]) | (sel[1] & ~b_in[i]);
  end

  always_comb begin
    if (!$isunknown({sel, b_in})) begin
      if (sel == YG_ZERO) a_r1_zero_leg: assert (y_out == '0);
      if (sel == YG_PASS) a_r2_pass_leg: assert (y_out == b_in);
      if (sel == YG_INV)  a_r3_inv_leg:  assert ((y_out ^ b_in) == '1);
      if (sel == YG_ONES) a_r4_ones_leg: assert (&y_out);
    end
  end
endmodule

// File: rtl/sel_alu_fa.sv
module sel_alu_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hx;
  assign hx = x ^ y;
  assign s  = hx ^ ci;
  assign co = (x & y) | (hx & ci);
endmodule

// File: rtl/sel_alu_ripple.sv
module sel_alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_stage
    sel_alu_fa u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (s[i]),
      .co (chain[i+1])
    );
  end

  assign co = chain[W];

  always_comb begin
    if (!$isunknown({x, y, ci})) begin
      // R7: the chain's last carry is the true carry out of the top bit
      a_r7_carry_chain: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}));
    end
  end
endmodule

// File: rtl/sel_alu_logic.sv
module sel_alu_logic #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   sel,
  output logic [W-1:0] l_out
);
  import sel_alu_pkg::*;

  lf_sel_e fsel;
  assign fsel = lf_sel_e'(sel);

  always_comb begin
    unique case (fsel)
      LF_OR:   l_out = a_in | b_in;
      LF_AND:  l_out = a_in & b_in;
      LF_XOR:  l_out = a_in ^ b_in;
      LF_NOTA: l_out = ~a_in;
      default: l_out = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({sel, a_in, b_in})) begin
      if (sel == 2'b11) a_r5_not_leg: assert ((l_out ^ a_in) == '1);
      if (sel == 2'b01) a_r5_and_sub: assert ((l_out & ~a_in) == '0);
    end
  end
endmodule

// File: rtl/sel_alu.sv
module sel_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [1:0]   op_sel,
  input  logic         logic_mode,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W-1:0] y_op;
  logic [W-1:0] arith_s;
  logic         arith_c;
  logic [W-1:0] logic_r;

  sel_alu_opgen #(.W(W)) u_opgen (
    .b_in  (opb),
    .sel   (op_sel),
    .y_out (y_op)
  );

  sel_alu_ripple #(.W(W)) u_add (
    .x  (opa),
    .y  (y_op),
    .ci (cin),
    .s  (arith_s),
    .co (arith_c)
  );

  sel_alu_logic #(.W(W)) u_logic (
    .a_in  (opa),
    .b_in  (opb),
    .sel   (op_sel),
    .l_out (logic_r)
  );

  assign res  = logic_mode ? logic_r : arith_s;
  assign cout = arith_c & ~logic_mode;

  always_comb begin
    if (!$isunknown({opa, opb, cin, op_sel, logic_mode})) begin
      if (logic_mode) a_r6_no_carry_logic: assert (cout == 1'b0);
      if (!logic_mode && op_sel == 2'b11 && cin)
        a_r4_transfer_carry: assert (cout && res == opa);
      if (!logic_mode && op_sel == 2'b00 && !cin)
        a_r1_transfer_plain: assert (!cout && res == opa);
    end
  end
endmodule

// File: tb/sim_sel_alu.sv
module sim_sel_alu;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa = '0, opb = '0;
  logic         cin = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic         logic_mode = 1'b0;
  logic [W-1:0] res;
  logic         cout;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sel_alu #(.W(W)) u0 (
    .opa(opa), .opb(opb), .cin(cin), .op_sel(op_sel),
    .logic_mode(logic_mode), .res(res), .cout(cout)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit c, input int s, input bit m);
    @(negedge clk);
    opa = W'(a); opb = W'(b); cin = c; op_sel = 2'(s); logic_mode = m;
    #1;
  endtask

  function automatic int ref_arith(input int a, input int b, input bit c, input int s);
    int y;
    case (s)
      0: y = 0;
      1: y = b;
      2: y = (~b) & 15;
      default: y = 15;
    endcase
    return a + y + c;
  endfunction

  task automatic t_reset_state();
    apply(0, 0, 0, 0, 0);
    check("R1 idle res", res, 0);
    check("R1 idle cout", cout, 0);
  endtask

  task automatic t_arith_sweep();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            int e;
            string tag;
            apply(a, b, c[0], s, 1'b0);
            e = ref_arith(a, b, c[0], s);
            tag = (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : "R4";
            check(tag, {cout, res}, e);
          end
  endtask

  task automatic t_logic_sweep();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            int e;
            apply(a, b, c[0], s, 1'b1);
            case (s)
              0: e = a | b;
              1: e = a & b;
              2: e = a ^ b;
              default: e = (~a) & 15;
            endcase
            check("R5 logic res", res, e);
            check("R6 logic cout", cout, 0);
          end
  endtask

  task automatic t_carry_corners();
    apply(0, 0, 0, 3, 0);   check("R4 dec zero", {cout, res}, 5'h0F);
    apply(1, 0, 0, 3, 0);   check("R4 dec one", {cout, res}, 5'h10);
    apply(15, 0, 1, 0, 0);  check("R1 inc wrap", {cout, res}, 5'h10);
    apply(7, 7, 1, 2, 0);   check("R3 equal sub", {cout, res}, 5'h10);
    apply(6, 7, 1, 2, 0);   check("R3 borrow", {cout, res}, 5'h0F);
    apply(9, 9, 0, 3, 1);   check("R6 cin0", res, 6);
    apply(9, 9, 1, 3, 1);   check("R6 cin1", res, 6);
  endtask

  task automatic t_chain();
    for (int k = 0; k < 6; k++) begin
      int a8, b8, lo, hi;
      a8 = (k * 73 + 19) & 255;
      b8 = (k * 151 + 88) & 255;
      apply(a8 & 15, b8 & 15, 0, 1, 0);
      lo = res;
      apply(a8 >> 4, b8 >> 4, cout, 1, 0);
      hi = {cout, res};
      check("R7 chained add", (hi << 4) | lo, a8 + b8);
      apply(a8 & 15, b8 & 15, 1, 2, 0);
      lo = res;
      apply(a8 >> 4, b8 >> 4, cout, 2, 0);
      hi = {cout, res};
      check("R7 chained sub", (hi << 4) | lo, a8 + ((~b8) & 255) + 1);
    end
  endtask

  initial begin
    t_reset_state();
    t_carry_corners();
    t_arith_sweep();
    t_logic_sweep();
    t_chain();
    done = 1'b1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule